// File: doc/BRIEF.md
# Debug Mode Entry Controller

This block decides when a processor core switches from normal execution into its active debug mode, and which request caused the switch. Three request kinds reach it: a signal from the decode stage that a debug-halt instruction has just retired, a halt command arriving from the serial debug link, and a breakpoint request with a type bit. The breakpoint type chooses whether the core stops before the next instruction or after it. Every entry waits for the current instruction to finish. The block asks the pipeline to stop at the next instruction boundary and watches for the boundary strobe before it declares debug mode active.

A global enable gates every source, but a disabled request does not always do nothing. A halt command or breakpoint that arrives while debug is disabled is dropped and costs no cycles. A debug-halt instruction that retires while debug is disabled stalls the core for a parameterised number of cycles, after which normal execution resumes. While debug mode is active, an overlay window over the top 256 bytes of the 18-bit address space is switched on. Its lowest twelve bytes select the debug registers, and only non-user accesses may reach them. If the program counter captured at entry falls inside the overlay window, a flag is raised. A resume command is then refused until a write-PC command clears that flag.

The state machine has five states. RUN is idle. WAIT_BND holds the boundary halt request. SKIP_ONE lets one more instruction complete for an after-type breakpoint. ACTIVE is debug mode. STALL is the penalty for a disabled halt instruction. The transitions are:
- RUN to ACTIVE on an enabled halt instruction.
- RUN to STALL on a disabled halt instruction.
- RUN to WAIT_BND on an enabled before-type breakpoint or an enabled halt command.
- RUN to SKIP_ONE on an enabled after-type breakpoint.
- SKIP_ONE to WAIT_BND on a boundary.
- WAIT_BND to ACTIVE on a boundary.
- ACTIVE to RUN on an accepted resume.
- STALL to RUN when the stall count expires.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: After reset, dbg_active, halt_req, stall_req, overlay_en, pc_in_window and dbgreg_sel are 0 and entry_src is 0.
- R2: When several requests arrive in the same idle cycle, the halt instruction wins over a breakpoint, and a breakpoint wins over a halt command. entry_src records the winner while it is pending or active, encoded as 1 for the instruction, 2 for the command and 3 for the breakpoint, and reads 0 otherwise.
- R3: An enabled halt instruction (halt_insn high in an idle cycle) sets dbg_active at the next clock edge, with no halt request phase.
- R4: An enabled halt command, or an enabled breakpoint with bkpt_after=0, raises halt_req at the next edge. halt_req stays high until a cycle with insn_boundary high, and dbg_active rises at that edge.
- R5: An enabled breakpoint with bkpt_after=1 keeps halt_req low until the first insn_boundary. halt_req then rises, and dbg_active follows the second boundary.
- R6: While dbg_enable is 0, a halt command or a breakpoint has no effect: no stall, no halt request, no entry.
- R7: A halt instruction while dbg_enable is 0 drives stall_req high for exactly STALL_CYC cycles (default 4), starting at the next edge. The block then returns to idle without entering debug mode.
- R8: overlay_en is high in exactly the cycles in which dbg_active is high.
- R9: dbgreg_sel is high only when overlay_en is high, user_access is low and bus_addr lies in 0x3FF00 to 0x3FF0B.
- R10: At the entering edge, pc_in_window takes 1 if pc_in lies in 0x3FF00 to 0x3FFFF and 0 otherwise. write_pc_cmd during debug mode clears it at the next edge.
- R11: In debug mode, resume_cmd with pc_in_window low clears dbg_active and overlay_en at the next edge. With pc_in_window high, resume_cmd is ignored.
- R12: Requests that arrive while a halt is pending, while debug mode is active or during a stall are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbg_enable | input | 1 | Debug enable |
| halt_insn | input | 1 | Debug-halt instruction retired this cycle |
| ext_halt_cmd | input | 1 | Halt command from serial debug link |
| bkpt_req | input | 1 | Breakpoint request |
| bkpt_after | input | 1 | Breakpoint type: 1 = after next instruction |
| insn_boundary | input | 1 | Instruction boundary strobe from pipeline |
| resume_cmd | input | 1 | Resume command |
| write_pc_cmd | input | 1 | Write-PC command |
| pc_in | input | 18 | Program counter of the interrupted flow |
| bus_addr | input | 18 | Current bus access address |
| user_access | input | 1 | Access originates from user code |
| dbg_active | output | 1 | Debug mode active |
| halt_req | output | 1 | Request to halt at next instruction boundary |
| stall_req | output | 1 | Request to stall the core |
| overlay_en | output | 1 | Overlay window enable |
| pc_in_window | output | 1 | Captured PC inside overlay window |
| dbgreg_sel | output | 1 | Debug register select for current access |
| entry_src | output | 2 | Source of the pending or active entry |

## Verification
Directed sequences separate the per-source paths. Comparing enabled and disabled runs of each source distinguishes a dropped request from a stalled one. A before-type and an after-type breakpoint run under the same boundary pattern shows whether the extra instruction is counted. Simultaneous requests expose the priority order. Entry PCs inside and outside the window, resumes with and without a preceding write-PC, and register-select addresses at 0x3FF0B versus 0x3FF0C with both user settings cover the overlay rules. A seeded random stream of sparse requests against dense boundary strobes then checks every output, in every cycle, against a bench model.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;

    typedef enum logic [2:0] {
        ST_RUN      = 3'd0,
        ST_WAIT_BND = 3'd1,
        ST_SKIP_ONE = 3'd2,
        ST_ACTIVE   = 3'd3,
        ST_STALL    = 3'd4
    } dbg_state_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_INSN = 2'd1,
        SRC_CMD  = 2'd2,
        SRC_BKPT = 2'd3
    } dbg_src_e;

endpackage

// File: rtl/dbg_window_match.sv
module dbg_window_match #(
    parameter int               ADDR_W = 18,
    parameter logic [ADDR_W-1:0] BASE  = '0,
    parameter int               SPAN   = 256
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam logic [ADDR_W:0] SPAN_EXT = (ADDR_W+1)'(SPAN);

    logic [ADDR_W:0] offset;

    always_comb begin
        offset = {1'b0, addr} - {1'b0, BASE};
        hit    = !offset[ADDR_W] && (offset < SPAN_EXT);
    end
endmodule

// File: rtl/dbg_stall_timer.sv
module dbg_stall_timer #(
    parameter int CNT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int CW = $clog2(CNT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CW'(CNT);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb done = (cnt_q == CW'(1));
endmodule

// File: rtl/dbg_entry_fsm.sv
module dbg_entry_fsm
    import dbg_entry_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dbg_enable,
    input  logic       halt_insn,
    input  logic       ext_halt_cmd,
    input  logic       bkpt_req,
    input  logic       bkpt_after,
    input  logic       insn_boundary,
    input  logic       resume_cmd,
    input  logic       write_pc_cmd,
    input  logic       pc_hit,
    input  logic       stall_done,
    output logic       stall_start,
    output logic       dbg_active,
    output logic       halt_req,
    output logic       stall_req,
    output logic       pc_flag,
    output logic [1:0] entry_src
);
    dbg_state_e state_q, state_d;
    dbg_src_e   src_q, src_d;
    logic       flag_q, flag_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            src_q   <= SRC_NONE;
            flag_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            src_q   <= src_d;
            flag_q  <= flag_d;
        end
    end

    // transitions
    always_comb begin
        state_d     = state_q;
        src_d       = src_q;
        flag_d      = flag_q;
        stall_start = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (halt_insn) begin
                    if (dbg_enable) begin
                        state_d = ST_ACTIVE;
                        src_d   = SRC_INSN;
                        flag_d  = pc_hit;
                    end else begin
                        state_d     = ST_STALL;
                        stall_start = 1'b1;
                    end
                end else if (bkpt_req && dbg_enable) begin
                    src_d   = SRC_BKPT;
                    state_d = bkpt_after ? ST_SKIP_ONE : ST_WAIT_BND;
                end else if (ext_halt_cmd && dbg_enable) begin
                    src_d   = SRC_CMD;
                    state_d = ST_WAIT_BND;
                end
            end
            ST_SKIP_ONE: begin
                if (insn_boundary) state_d = ST_WAIT_BND;
            end
            ST_WAIT_BND: begin
                if (insn_boundary) begin
                    state_d = ST_ACTIVE;
                    flag_d  = pc_hit;
                end
            end
            ST_ACTIVE: begin
                if (write_pc_cmd) flag_d = 1'b0;
                if (resume_cmd && !flag_q) begin
                    state_d = ST_RUN;
                    src_d   = SRC_NONE;
                end
            end
            ST_STALL: begin
                if (stall_done) state_d = ST_RUN;
            end
            default: begin
                state_d = ST_RUN;
                src_d   = SRC_NONE;
            end
        endcase
    end

    // outputs
    always_comb begin
        dbg_active = 1'b0;
        halt_req   = 1'b0;
        stall_req  = 1'b0;
        unique case (state_q)
            ST_RUN, ST_SKIP_ONE: ;
            ST_WAIT_BND: halt_req   = 1'b1;
            ST_ACTIVE:   dbg_active = 1'b1;
            ST_STALL:    stall_req  = 1'b1;
            default: ;
        endcase
        pc_flag   = flag_q;
        entry_src = src_q;
    end
endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl #(
    parameter int                ADDR_W    = 18,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 18'h3FF00,
    parameter int                WIN_SPAN  = 256,
    parameter int                REG_COUNT = 12,
    parameter int                STALL_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbg_enable,
    input  logic              halt_insn,
    input  logic              ext_halt_cmd,
    input  logic              bkpt_req,
    input  logic              bkpt_after,
    input  logic              insn_boundary,
    input  logic              resume_cmd,
    input  logic              write_pc_cmd,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              user_access,
    output logic              dbg_active,
    output logic              halt_req,
    output logic              stall_req,
    output logic              overlay_en,
    output logic              pc_in_window,
    output logic              dbgreg_sel,
    output logic [1:0]        entry_src
);
    logic pc_hit, reg_hit, stall_start, stall_done;

    dbg_window_match #(.ADDR_W(ADDR_W), .BASE(WIN_BASE), .SPAN(WIN_SPAN)) u_pc_win (
        .addr (pc_in),
        .hit  (pc_hit)
    );

    dbg_window_match #(.ADDR_W(ADDR_W), .BASE(WIN_BASE), .SPAN(REG_COUNT)) u_reg_win (
        .addr (bus_addr),
        .hit  (reg_hit)
    );

    dbg_stall_timer #(.CNT(STALL_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (stall_start),
        .done  (stall_done)
    );

    dbg_entry_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .dbg_enable    (dbg_enable),
        .halt_insn     (halt_insn),
        .ext_halt_cmd  (ext_halt_cmd),
        .bkpt_req      (bkpt_req),
        .bkpt_after    (bkpt_after),
        .insn_boundary (insn_boundary),
        .resume_cmd    (resume_cmd),
        .write_pc_cmd  (write_pc_cmd),
        .pc_hit        (pc_hit),
        .stall_done    (stall_done),
        .stall_start   (stall_start),
        .dbg_active    (dbg_active),
        .halt_req      (halt_req),
        .stall_req     (stall_req),
        .pc_flag       (pc_in_window),
        .entry_src     (entry_src)
    );

    always_comb begin
        overlay_en = dbg_active;
        dbgreg_sel = overlay_en && !user_access && reg_hit;
    end
endmodule

// File: rtl/dbg_entry_ctrl_chk.sv
module dbg_entry_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       dbg_enable,
    input logic       halt_insn,
    input logic       ext_halt_cmd,
    input logic       bkpt_req,
    input logic       insn_boundary,
    input logic       resume_cmd,
    input logic       write_pc_cmd,
    input logic       user_access,
    input logic       dbg_active,
    input logic       halt_req,
    input logic       stall_req,
    input logic       overlay_en,
    input logic       pc_in_window,
    input logic       dbgreg_sel,
    input logic [1:0] entry_src
);
    logic idle;
    always_comb idle = (entry_src == 2'd0) && !stall_req;

    a_r3_insn_enters: assert property (@(posedge clk) disable iff (!rst_n)
        idle && halt_insn && dbg_enable |=> dbg_active);

    a_r6_cmd_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        idle && ext_halt_cmd && !dbg_enable && !halt_insn && !bkpt_req
        |=> !stall_req && !halt_req && !dbg_active && entry_src == 2'd0);

    a_r7_disabled_stall: assert property (@(posedge clk) disable iff (!rst_n)
        idle && halt_insn && !dbg_enable |=> stall_req && !dbg_active);

    a_r4_boundary_entry: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req && insn_boundary |=> dbg_active);

    a_r11_resume_exit: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_active && resume_cmd && !pc_in_window |=> !dbg_active && !overlay_en);

    a_r11_resume_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_active && resume_cmd && pc_in_window |=> dbg_active);

    a_r9_regsel_gated: assert property (@(posedge clk) disable iff (!rst_n)
        dbgreg_sel |-> overlay_en && !user_access);

    a_r10_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_active && write_pc_cmd |=> !pc_in_window);
endmodule

bind dbg_entry_ctrl dbg_entry_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .dbg_enable    (dbg_enable),
    .halt_insn     (halt_insn),
    .ext_halt_cmd  (ext_halt_cmd),
    .bkpt_req      (bkpt_req),
    .insn_boundary (insn_boundary),
    .resume_cmd    (resume_cmd),
    .write_pc_cmd  (write_pc_cmd),
    .user_access   (user_access),
    .dbg_active    (dbg_active),
    .halt_req      (halt_req),
    .stall_req     (stall_req),
    .overlay_en    (overlay_en),
    .pc_in_window  (pc_in_window),
    .dbgreg_sel    (dbgreg_sel),
    .entry_src     (entry_src)
);

// File: tb/dbg_entry_ctrl_tb.sv
module dbg_entry_ctrl_tb;
    localparam int          STALL = 4;
    localparam logic [17:0] BASE  = 18'h3FF00;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, hi = 1'b0, cmd = 1'b0, bk = 1'b0, bka = 1'b0, bnd = 1'b0;
    logic res = 1'b0, wpc = 1'b0, usr = 1'b0;
    logic [17:0] pc = '0, ba = '0;
    logic act, hreq, sreq, ovl, pflag, rsel;
    logic [1:0] src;

    int vectors = 0;
    int fails = 0;

    // bench model: 0 run, 1 wait, 2 skip, 3 active, 4 stall
    int mst = 0, mcnt = 0, msrc = 0;
    bit mflag = 1'b0;

    always #4 clk = ~clk;

    dbg_entry_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .dbg_enable(en), .halt_insn(hi),
        .ext_halt_cmd(cmd), .bkpt_req(bk), .bkpt_after(bka),
        .insn_boundary(bnd), .resume_cmd(res), .write_pc_cmd(wpc),
        .pc_in(pc), .bus_addr(ba), .user_access(usr),
        .dbg_active(act), .halt_req(hreq), .stall_req(sreq),
        .overlay_en(ovl), .pc_in_window(pflag), .dbgreg_sel(rsel),
        .entry_src(src)
    );

    function automatic bit in_win(logic [17:0] a);
        return a >= BASE;
    endfunction

    function automatic bit in_regs(logic [17:0] a);
        return (a >= BASE) && (a < BASE + 18'd12);
    endfunction

    task automatic chk(string tag, int act_v, int exp_v);
        vectors++;
        if (act_v != exp_v) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act_v, exp_v, $time);
        end
    endtask

    task automatic model_step();
        bit leave;
        case (mst)
            0: begin
                if (hi) begin
                    if (en) begin mst = 3; msrc = 1; mflag = in_win(pc); end
                    else begin mst = 4; mcnt = STALL; end
                end else if (bk && en) begin
                    msrc = 3; mst = bka ? 2 : 1;
                end else if (cmd && en) begin
                    msrc = 2; mst = 1;
                end
            end
            1: if (bnd) begin mst = 3; mflag = in_win(pc); end
            2: if (bnd) mst = 1;
            3: begin
                leave = res && !mflag;
                if (wpc) mflag = 1'b0;
                if (leave) begin mst = 0; msrc = 0; end
            end
            4: begin mcnt--; if (mcnt == 0) mst = 0; end
            default: mst = 0;
        endcase
    endtask

    task automatic compare_all();
        chk("R3/R4/R5 dbg_active", int'(act), int'(mst == 3));
        chk("R4/R5 halt_req", int'(hreq), int'(mst == 1));
        chk("R7 stall_req", int'(sreq), int'(mst == 4));
        chk("R8 overlay_en", int'(ovl), int'(mst == 3));
        chk("R10 pc_in_window", int'(pflag), int'(mflag));
        chk("R9 dbgreg_sel", int'(rsel), int'(mst == 3 && !usr && in_regs(ba)));
        chk("R2 entry_src", int'(src), msrc);
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic clr();
        hi = 0; cmd = 0; bk = 0; bka = 0; bnd = 0; res = 0; wpc = 0;
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0001));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 dbg_active", int'(act), 0);
        chk("R1 halt_req", int'(hreq), 0);
        chk("R1 stall_req", int'(sreq), 0);
        chk("R1 overlay_en", int'(ovl), 0);
        chk("R1 pc_in_window", int'(pflag), 0);
        chk("R1 entry_src", int'(src), 0);
        rst_n = 1'b1;

        // R6: disabled command and breakpoint dropped
        en = 0; cmd = 1; bk = 1; tick(); clr();
        chk("R6 no stall", int'(sreq), 0);
        chk("R6 no halt_req", int'(hreq), 0);
        tick();
        chk("R6 still idle", int'(src), 0);

        // R7: disabled halt instruction stalls STALL cycles
        hi = 1; tick(); clr();
        for (int i = 1; i < STALL; i++) begin
            chk("R7 stall held", int'(sreq), 1);
            tick();
        end
        chk("R7 stall last", int'(sreq), 1);
        tick();
        chk("R7 stall released", int'(sreq), 0);
        chk("R7 no entry", int'(act), 0);

        // R3, R10, R11: enabled halt instruction with PC in window
        en = 1; hi = 1; pc = BASE + 18'h40; tick(); clr();
        chk("R3 active next edge", int'(act), 1);
        chk("R10 flag set", int'(pflag), 1);
        chk("R2 src insn", int'(src), 1);
        hi = 1; cmd = 1; tick(); clr();        // R12: ignored while active
        chk("R12 still active", int'(act), 1);
        res = 1; tick(); clr();
        chk("R11 resume blocked", int'(act), 1);
        wpc = 1; tick(); clr();
        chk("R10 flag cleared", int'(pflag), 0);
        res = 1; tick(); clr();
        chk("R11 resume exits", int'(act), 0);
        chk("R8 overlay off", int'(ovl), 0);

        // R4: before-type breakpoint, PC outside window
        bk = 1; bka = 0; pc = 18'h01234; tick(); clr();
        chk("R4 halt_req", int'(hreq), 1);
        tick();
        chk("R4 waits boundary", int'(act), 0);
        hi = 1; tick(); clr();                 // R12: ignored while pending
        chk("R12 no stall while pending", int'(sreq), 0);
        bnd = 1; tick(); clr();
        chk("R4 entered", int'(act), 1);
        chk("R10 flag clear outside", int'(pflag), 0);
        // R9: register select
        ba = BASE + 18'd11; usr = 0; tick();
        chk("R9 last register", int'(rsel), 1);
        ba = BASE + 18'd12; tick();
        chk("R9 beyond registers", int'(rsel), 0);
        ba = BASE; usr = 1; tick();
        chk("R9 user blocked", int'(rsel), 0);
        usr = 0; res = 1; tick(); clr();
        chk("R9 no select when idle", int'(rsel), 0);

        // R5: after-type breakpoint
        bk = 1; bka = 1; tick(); clr();
        chk("R5 halt_req withheld", int'(hreq), 0);
        chk("R5 src bkpt", int'(src), 3);
        bnd = 1; tick(); clr();
        chk("R5 halt_req after first", int'(hreq), 1);
        bnd = 1; tick(); clr();
        chk("R5 entered after second", int'(act), 1);
        res = 1; tick(); clr();

        // R2: priority
        hi = 1; bk = 1; cmd = 1; tick(); clr();
        chk("R2 insn wins", int'(src), 1);
        res = 1; tick(); clr();
        bk = 1; cmd = 1; tick(); clr();
        chk("R2 bkpt over cmd", int'(src), 3);
        bnd = 1; tick(); clr();
        res = 1; tick(); clr();
        cmd = 1; tick(); clr();
        chk("R2 src cmd", int'(src), 2);
        bnd = 1; tick(); clr();
        res = 1; tick(); clr();

        // seeded random stream
        for (int n = 0; n < 4000; n++) begin
            en  = ($urandom % 100) < 85;
            hi  = ($urandom % 100) < 3;
            cmd = ($urandom % 100) < 4;
            bk  = ($urandom % 100) < 4;
            bka = $urandom % 2;
            bnd = ($urandom % 100) < 40;
            res = ($urandom % 100) < 10;
            wpc = ($urandom % 100) < 8;
            pc  = (($urandom % 100) < 30) ? BASE + 18'($urandom % 256) : 18'($urandom);
            ba  = (($urandom % 2) == 0) ? BASE + 18'($urandom % 16) : 18'($urandom);
            usr = $urandom % 2;
            tick();
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule